// File: doc/BRIEF.md
# AXI4-Lite GPIO Register Slave

This block is a general-purpose I/O port that a processor controls over an AXI4-Lite slave interface. It has three word registers. The first is a pin-level register that drives the GPIO outputs. The second is a per-pin enable register that selects which pins are driven. The third is a read-only image of the GPIO inputs, taken after a two-flop synchroniser. The outputs reach the pad ring as a value vector and an enable vector. A pad drives its pin only where the enable bit is 1.

The write address and the write data are captured independently. Either may arrive first, both may arrive in the same cycle, and any number of cycles may separate them. The register write happens as soon as both are held, and a write response follows. Reads use their own logic, so a read can proceed while a write is pending. Only one write and one read are outstanding at a time. Every response is OKAY.

Top module: `gpio_axil`

## Requirements
- R1: While rst_ni is low and after its release, bvalid_o and rvalid_o are 0, awready_o, wready_o and arready_o are 1, and gpio_o and gpio_oe_o are all 0, so every pin is an input.
- R2: A write completes correctly for every arrival order of address and data, and for every skew between them from 0 to several cycles. The register later reads back the data that was written.
- R3: Once a handshake completes on the write-address channel, awready_o stays 0 until the write-response handshake completes, and it is 1 again in the cycle after that handshake. The same holds for wready_o on the write-data channel.
- R4: bvalid_o rises on the clock edge where the second of address and data is accepted. It then stays 1, with bresp_o stable at 2'b00, until bready_i is seen high.
- R5: rvalid_o is 0 in the cycle of the read-address handshake and 1 in the next cycle. rvalid_o and rdata_o then stay stable until rready_i is high, and arready_o is 0 while rvalid_o is 1.
- R6: Address bits [3:2] select the register: 0 selects the output value (read/write, drives gpio_o), 1 selects the enable (read/write, drives gpio_oe_o, 1 = output) and 2 selects the input image (read-only). Bits [1:0] are ignored. gpio_o and gpio_oe_o change only on the edge where a write is committed.
- R7: wstrb_i bit k enables the write of data bits [8k+7:8k] into a writable register. Bits whose strobe is 0 keep their value.
- R8: Writes to index 2 or index 3 change no register. Reads of index 3 return 0. bresp_o and rresp_o are always 2'b00.
- R9: A gpio_i change made before clock edge k is not seen by a read whose address handshake is at edge k. It is seen by a read whose handshake is at edge k+2 or later.
- R10: A read of any register completes while a write is pending, and a write completes while a read is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| awaddr_i | input | ADDR_W | Write address |
| awvalid_i | input | 1 | Write address valid |
| awready_o | output | 1 | Write address ready |
| wdata_i | input | 32 | Write data |
| wstrb_i | input | 4 | Write byte strobes |
| wvalid_i | input | 1 | Write data valid |
| wready_o | output | 1 | Write data ready |
| bresp_o | output | 2 | Write response (always OKAY) |
| bvalid_o | output | 1 | Write response valid |
| bready_i | input | 1 | Write response ready |
| araddr_i | input | ADDR_W | Read address |
| arvalid_i | input | 1 | Read address valid |
| arready_o | output | 1 | Read address ready |
| rdata_o | output | 32 | Read data |
| rresp_o | output | 2 | Read response (always OKAY) |
| rvalid_o | output | 1 | Read data valid |
| rready_i | input | 1 | Read data ready |
| gpio_i | input | GPIO_W | GPIO input pins |
| gpio_o | output | GPIO_W | GPIO output values |
| gpio_oe_o | output | GPIO_W | GPIO output enables, 1 = drive |

## Verification
The riskiest fault is a held address that is used in the wrong cycle, for example when data arrives in the same cycle or one cycle after the address. This shows at the ports as a wrong gpio_o or gpio_oe_o on the edge of the commit. It also shows as a wrong word when the register is next read back. A ready flag that is not cleared or restored shows in the first cycle after the handshake: awready_o or wready_o is wrong there, or a response is lost. A synchroniser with the wrong depth shows as an input that becomes visible one edge too early or too late.

// File: rtl/gpio_axil_pkg.sv
package gpio_axil_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned STRB_W = DATA_W / 8;
  localparam logic [1:0]  RESP_OKAY = 2'b00;

  typedef enum logic [1:0] {
    SEL_OUT  = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_IN   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [31:0] addr);
    if (addr[31:4] != '0) return SEL_NONE;
    return reg_sel_e'(addr[3:2]);
  endfunction
endpackage

// File: rtl/gpio_axil_sync.sv
module gpio_axil_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/gpio_axil_wch.sv
module gpio_axil_wch
  import gpio_axil_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STRB_W-1:0] wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  output logic              cmt_o,
  output logic [ADDR_W-1:0] cmt_addr_o,
  output logic [DATA_W-1:0] cmt_data_o,
  output logic [STRB_W-1:0] cmt_strb_o
);
  logic              aw_held_q, w_held_q, bvalid_q;
  logic [ADDR_W-1:0] aw_addr_q;
  logic [DATA_W-1:0] w_data_q;
  logic [STRB_W-1:0] w_strb_q;
  logic aw_hs, w_hs, b_hs;

  assign awready_o = !aw_held_q;
  assign wready_o  = !w_held_q;
  assign bvalid_o  = bvalid_q;
  assign aw_hs = awvalid_i && awready_o;
  assign w_hs  = wvalid_i && wready_o;
  assign b_hs  = bvalid_q && bready_i;

  // a value arriving this cycle bypasses its holding register
  assign cmt_o      = (aw_held_q || aw_hs) && (w_held_q || w_hs) && !bvalid_q;
  assign cmt_addr_o = aw_held_q ? aw_addr_q : awaddr_i;
  assign cmt_data_o = w_held_q ? w_data_q : wdata_i;
  assign cmt_strb_o = w_held_q ? w_strb_q : wstrb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_held_q <= 1'b0;
      w_held_q  <= 1'b0;
      bvalid_q  <= 1'b0;
      aw_addr_q <= '0;
      w_data_q  <= '0;
      w_strb_q  <= '0;
    end else begin
      if (aw_hs) begin
        aw_held_q <= 1'b1;
        aw_addr_q <= awaddr_i;
      end
      if (w_hs) begin
        w_held_q <= 1'b1;
        w_data_q <= wdata_i;
        w_strb_q <= wstrb_i;
      end
      if (cmt_o) bvalid_q <= 1'b1;
      if (b_hs) begin
        bvalid_q  <= 1'b0;
        aw_held_q <= 1'b0;
        w_held_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gpio_axil_rch.sv
module gpio_axil_rch
  import gpio_axil_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] rd_word_i
);
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  assign arready_o = !rvalid_q;
  assign rvalid_o  = rvalid_q;
  assign rdata_o   = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (arvalid_i && arready_o) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_word_i;
    end else if (rvalid_q && rready_i) begin
      rvalid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_axil.sv
module gpio_axil
  import gpio_axil_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned GPIO_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [31:0]       rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  input  logic [GPIO_W-1:0] gpio_i,
  output logic [GPIO_W-1:0] gpio_o,
  output logic [GPIO_W-1:0] gpio_oe_o
);
  localparam int unsigned PAD_W = DATA_W - GPIO_W;

  logic              cmt;
  logic [ADDR_W-1:0] cmt_addr;
  logic [DATA_W-1:0] cmt_data;
  logic [STRB_W-1:0] cmt_strb;
  logic [GPIO_W-1:0] out_q, dir_q, in_sync;
  logic [DATA_W-1:0] rd_word;
  reg_sel_e          wr_sel, rd_sel;

  gpio_axil_wch #(.ADDR_W(ADDR_W)) u_wch (
    .clk_i, .rst_ni,
    .awaddr_i, .awvalid_i, .awready_o,
    .wdata_i, .wstrb_i, .wvalid_i, .wready_o,
    .bvalid_o, .bready_i,
    .cmt_o(cmt), .cmt_addr_o(cmt_addr), .cmt_data_o(cmt_data), .cmt_strb_o(cmt_strb)
  );

  gpio_axil_rch u_rch (
    .clk_i, .rst_ni,
    .arvalid_i, .arready_o,
    .rvalid_o, .rready_i, .rdata_o,
    .rd_word_i(rd_word)
  );

  gpio_axil_sync #(.W(GPIO_W)) u_sync (
    .clk_i, .rst_ni, .d_i(gpio_i), .q_o(in_sync)
  );

  assign bresp_o = RESP_OKAY;
  assign rresp_o = RESP_OKAY;
  assign wr_sel  = decode(32'(cmt_addr));
  assign rd_sel  = decode(32'(araddr_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '0;
    end else if (cmt) begin
      for (int b = 0; b < GPIO_W; b++) begin
        if (cmt_strb[b/8]) begin
          if (wr_sel == SEL_OUT) out_q[b] <= cmt_data[b];
          if (wr_sel == SEL_DIR) dir_q[b] <= cmt_data[b];
        end
      end
    end
  end

  always_comb begin
    unique case (rd_sel)
      SEL_OUT: rd_word = {{PAD_W{1'b0}}, out_q};
      SEL_DIR: rd_word = {{PAD_W{1'b0}}, dir_q};
      SEL_IN:  rd_word = {{PAD_W{1'b0}}, in_sync};
      default: rd_word = '0;
    endcase
  end

  assign gpio_o    = out_q;
  assign gpio_oe_o = dir_q;
endmodule

// File: rtl/gpio_axil_chk.sv
module gpio_axil_chk #(
  parameter int unsigned GPIO_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              awvalid_i,
  input logic              awready_o,
  input logic              wvalid_i,
  input logic              wready_o,
  input logic              bvalid_o,
  input logic              bready_i,
  input logic [1:0]        bresp_o,
  input logic              arvalid_i,
  input logic              arready_o,
  input logic              rvalid_o,
  input logic              rready_i,
  input logic [31:0]       rdata_o,
  input logic [1:0]        rresp_o,
  input logic [GPIO_W-1:0] gpio_o,
  input logic [GPIO_W-1:0] gpio_oe_o
);
  assert_aw_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awvalid_i && awready_o) |=> !awready_o);
  assert_aw_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!awready_o && !(bvalid_o && bready_i)) |=> !awready_o);
  assert_w_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wvalid_i && wready_o) |=> !wready_o);
  assert_w_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wready_o && !(bvalid_o && bready_i)) |=> !wready_o);
  assert_b_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bvalid_o && !bready_i) |=> (bvalid_o && $stable(bresp_o)));
  assert_bresp_okay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_o |-> (bresp_o == 2'b00));
  assert_r_next_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arvalid_i && arready_o) |=> rvalid_o);
  assert_r_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rvalid_o) |-> $past(arvalid_i && arready_o));
  assert_r_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !rready_i) |=> (rvalid_o && $stable(rdata_o)));
  assert_rresp_okay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (rresp_o == 2'b00));
  assert_pins_on_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(gpio_o) && $stable(gpio_oe_o)) |-> $rose(bvalid_o));
endmodule

bind gpio_axil gpio_axil_chk #(.GPIO_W(GPIO_W)) u_chk (.*);

// File: tb/gpio_axil_tb_top.sv
module gpio_axil_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic [GW-1:0] gin = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic [GW-1:0] gout, goe;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [GW-1:0] m_out = '0, m_dir = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_axil #(.ADDR_W(4), .GPIO_W(GW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .awaddr_i(awaddr), .awvalid_i(awvalid), .awready_o(awready),
    .wdata_i(wdata), .wstrb_i(wstrb), .wvalid_i(wvalid), .wready_o(wready),
    .bresp_o(bresp), .bvalid_o(bvalid), .bready_i(bready),
    .araddr_i(araddr), .arvalid_i(arvalid), .arready_o(arready),
    .rdata_o(rdata), .rresp_o(rresp), .rvalid_o(rvalid), .rready_i(rready),
    .gpio_i(gin), .gpio_o(gout), .gpio_oe_o(goe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [GW-1:0] apply(input logic [GW-1:0] old, input logic [31:0] d, input logic [3:0] s);
    logic [GW-1:0] r = old;
    for (int b = 0; b < GW; b++) if (s[b/8]) r[b] = d[b];
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    case (a[3:2])
      2'd0: return 32'(m_out);
      2'd1: return 32'(m_dir);
      2'd2: return 32'(gin);
      default: return 32'h0;
    endcase
  endfunction

  // called and returns at a falling edge; ad/wd = cycles before each valid, bd = bready delay
  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s,
                    input int ad, input int wd, input int bd);
    bit aw_done = 0, w_done = 0, aw_hs, w_hs;
    int t = 0;
    while (!(aw_done && w_done)) begin
      if (aw_done) awvalid = 0;
      if (w_done) wvalid = 0;
      if (!aw_done && t >= ad) begin awvalid = 1; awaddr = a; end
      if (!w_done && t >= wd) begin wvalid = 1; wdata = d; wstrb = s; end
      #1;
      if (aw_done) check(awready == 0, "R3 awready held low", 32'(awready), 0);
      if (w_done)  check(wready == 0, "R3 wready held low", 32'(wready), 0);
      check(bvalid == 0, "R4 no early bvalid", 32'(bvalid), 0);
      aw_hs = awvalid && awready;
      w_hs  = wvalid && wready;
      @(posedge clk);
      if (aw_hs) aw_done = 1;
      if (w_hs) w_done = 1;
      @(negedge clk);
      t++;
    end
    awvalid = 0; wvalid = 0;
    case (a[3:2])
      2'd0: m_out = apply(m_out, d, s);
      2'd1: m_dir = apply(m_dir, d, s);
      default: ;
    endcase
    check(bvalid == 1 && bresp == 2'b00, "R4 bvalid after commit", {bvalid, bresp}, 3'b100);
    check(gout == m_out, "R6 gpio_o after commit", 32'(gout), 32'(m_out));
    check(goe == m_dir, "R6 gpio_oe_o after commit", 32'(goe), 32'(m_dir));
    for (int i = 0; i < bd; i++) begin
      @(negedge clk);
      check(bvalid == 1 && bresp == 2'b00, "R4 bvalid held", {bvalid, bresp}, 3'b100);
    end
    bready = 1;
    @(negedge clk);
    bready = 0;
    check(bvalid == 0 && awready == 1 && wready == 1, "R3 readies restored",
          {bvalid, awready, wready}, 3'b011);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input int rdly, input string req);
    logic [31:0] first;
    arvalid = 1; araddr = a;
    #1;
    while (!arready) begin @(negedge clk); #1; end
    check(rvalid == 0, "R5 no same-cycle rvalid", 32'(rvalid), 0);
    @(negedge clk);
    arvalid = 0;
    check(rvalid == 1 && arready == 0, "R5 rvalid next cycle", {rvalid, arready}, 2'b10);
    first = rdata;
    for (int i = 0; i < rdly; i++) begin
      @(negedge clk);
      check(rvalid == 1 && rdata == first, "R5 rdata held", rdata, first);
    end
    check(rdata == exp && rresp == 2'b00, req, rdata, exp);
    rready = 1;
    @(negedge clk);
    rready = 0;
    check(rvalid == 0, "R5 rvalid cleared", 32'(rvalid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check({bvalid, rvalid, awready, wready, arready} == 5'b00111, "R1 ready/valid in reset",
          {bvalid, rvalid, awready, wready, arready}, 5'b00111);
    check(gout == 0 && goe == 0, "R1 pins input in reset", {gout, goe}, 0);
    rst_n = 1;
    @(negedge clk);
    check({bvalid, rvalid, awready, wready, arready} == 5'b00111, "R1 after release",
          {bvalid, rvalid, awready, wready, arready}, 5'b00111);

    // R2 directed skews: data first, same cycle, data lagging by 1..3
    wr(4'h0, 32'h0000_A5C3, 4'hF, 0, 0, 0); rd(4'h0, 32'h0000_A5C3, 0, "R2 skew 0");
    wr(4'h4, 32'h0000_00F0, 4'hF, 0, 1, 1); rd(4'h4, 32'h0000_00F0, 1, "R2 skew 1");
    wr(4'h0, 32'h0000_1234, 4'hF, 0, 2, 0); rd(4'h0, 32'h0000_1234, 0, "R2 skew 2");
    wr(4'h0, 32'h0000_BEEF, 4'hF, 0, 3, 2); rd(4'h0, 32'h0000_BEEF, 0, "R2 skew 3");
    wr(4'h4, 32'h0000_0F0F, 4'hF, 2, 0, 0); rd(4'h4, 32'h0000_0F0F, 0, "R2 data first 2");
    wr(4'h4, 32'h0000_3C3C, 4'hF, 1, 0, 0); rd(4'h4, 32'h0000_3C3C, 0, "R2 data first 1");
    // R6 low address bits ignored
    wr(4'h3, 32'h0000_7777, 4'hF, 0, 0, 0); rd(4'h1, 32'h0000_7777, 0, "R6 low bits ignored");
    // R7 strobes
    wr(4'h0, 32'h0000_AA55, 4'h1, 0, 0, 0); rd(4'h0, 32'h0000_7755, 0, "R7 low byte only");
    wr(4'h0, 32'h0000_11FF, 4'h2, 1, 0, 0); rd(4'h0, 32'h0000_1155, 0, "R7 high byte only");
    // R8 ignored writes and unmapped read
    wr(4'h8, 32'hFFFF_FFFF, 4'hF, 0, 0, 0); rd(4'h0, 32'h0000_1155, 0, "R8 write to input ignored");
    wr(4'hC, 32'hFFFF_FFFF, 4'hF, 0, 1, 0); rd(4'h4, 32'h0000_3C3C, 0, "R8 unmapped write ignored");
    rd(4'hC, 32'h0, 0, "R8 unmapped read zero");
    // R9 synchroniser latency
    gin = 16'h0000; repeat (3) @(negedge clk);
    gin = 16'hC0DE;
    rd(4'h8, 32'h0, 0, "R9 immediate read sees old input");
    rd(4'h8, 32'h0000_C0DE, 0, "R9 input after sync");
    // R10 read and write in flight together
    fork
      wr(4'h0, 32'h0000_5A5A, 4'hF, 0, 2, 2);
      rd(4'h8, 32'h0000_C0DE, 1, "R10 read during write");
    join
    rd(4'h0, 32'h0000_5A5A, 0, "R10 write during read");

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [3:0] a = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 9) == 0) begin
        gin = GW'($urandom);
        repeat (3) @(negedge clk);
      end
      if ($urandom_range(0, 1) == 1)
        wr(a, $urandom, 4'($urandom), $urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 2));
      else
        rd(a, exp_rd(a), $urandom_range(0, 2), "R2 random readback");
    end
    summary();
  end
endmodule